// File: doc/BRIEF.md
# Retriggerable Delay Timer

This block is a watchdog-style timer driven by two single-cycle event strobes sampled on the system clock. A restart strobe arms the timer and clears its count. A reference tick strobe moves the count forward by one.

The expiry strobe is raised during the tick on which the number of ticks since the latest restart equals the programmed delay. Exactly one expiry follows each restart, unless a newer restart comes first and takes over. The restart strobe does not need to coincide with a tick.

The delay comes from a static input and is held constant while the timer runs. The expiry output is combinational from the tick strobe and the registered count, so it is always a subset of the ticks.

Top module: `retrig_delay_timer`

## Requirements
- R1: Out of reset the timer is disarmed, and `expire_o` stays 0 until the first `restart_i`, however many ticks arrive.
- R2: A cycle with `restart_i`=1 arms the timer and clears the count to 0. A tick in that same cycle is not counted.
- R3: Each cycle with `tick_i`=1 and `restart_i`=0 while armed advances the count by exactly one.
- R4: `expire_o` is 1 in the cycle of the N-th tick after the latest restart, where N is the effective delay. It is 1 only in a cycle where `tick_i`=1.
- R5: A restart before expiry discards the ticks counted so far. Expiry then comes N ticks after the newer restart.
- R6: After expiry the timer disarms. No further expiry occurs until another restart.
- R7: While disarmed the count is held at its saturated value. Any number of ticks, including more than 2^CNT_W, gives no expiry from wrap-around.
- R8: The effective delay N equals `delay_i`, except that `delay_i`=0 is treated as 1.
- R9: `expire_o` is 0 in any cycle where `restart_i`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; both strobes are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Restart event strobe: arms the timer and clears the count |
| tick_i | input | 1 | Reference event strobe that advances the count |
| delay_i | input | CNT_W | Static delay in ticks (0 is treated as 1) |
| expire_o | output | 1 | Expiry strobe, high on the N-th tick after the latest restart |

## Verification
`expire_o` is combinational, so it is due in the same cycle as the tick that completes the delay. The count and armed state change at the next rising edge after a restart or a tick. The bench drives both strobes just after the falling edge and compares `expire_o` one nanosecond later, in the same cycle. It then advances its own tick-count model, which is what the design register holds after the coming rising edge. Every cycle of every sweep is compared this way, so an expiry one tick early or one tick late is caught.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_RESTART = 2'd1,
    EV_ADVANCE = 2'd2
  } rdt_event_e;
endpackage

// File: rtl/rdt_event_arbiter.sv
module rdt_event_arbiter
  import rdt_pkg::*;
(
  input  logic       restart_i,
  input  logic       tick_i,
  output rdt_event_e ev_o,
  output logic       restart_o,
  output logic       advance_o
);
  // restart outranks a coincident tick
  function automatic rdt_event_e classify(input logic rs, input logic tk);
    if (rs)      return EV_RESTART;
    else if (tk) return EV_ADVANCE;
    else         return EV_NONE;
  endfunction

  always_comb begin
    ev_o      = classify(restart_i, tick_i);
    restart_o = (ev_o == EV_RESTART);
    advance_o = (ev_o == EV_ADVANCE);
  end
endmodule

// File: rtl/rdt_delay_clamp.sv
module rdt_delay_clamp #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] delay_i,
  output logic [CNT_W-1:0] delay_eff_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] d);
    return (d == '0) ? ONE : d;
  endfunction

  assign delay_eff_o = clamp(delay_i);
endmodule

// File: rtl/rdt_count_core.sv
module rdt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             advance_i,
  input  logic [CNT_W-1:0] delay_eff_i,
  output logic [CNT_W-1:0] count_o,
  output logic             armed_o,
  output logic             expire_o
);
  localparam int EXT_W = CNT_W + 1;

  // widened increment so the comparison cannot wrap
  function automatic logic [EXT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return {1'b0, c} + EXT_W'(1);
  endfunction

  function automatic logic hits(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] d);
    return bump(c) == {1'b0, d};
  endfunction

  logic [CNT_W-1:0] count_q;
  logic             armed_q;

  assign expire_o = armed_q && advance_i && hits(count_q, delay_eff_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      count_q <= '0;
      armed_q <= 1'b1;
    end else if (expire_o) begin
      count_q <= delay_eff_i;
      armed_q <= 1'b0;
    end else if (advance_i && armed_q) begin
      count_q <= bump(count_q)[CNT_W-1:0];
    end
  end

  assign count_o = count_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/retrig_delay_timer.sv
module retrig_delay_timer
  import rdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             expire_o
);
  rdt_event_e       ev_w;
  logic             restart_w;
  logic             advance_w;
  logic [CNT_W-1:0] delay_eff_w;
  logic [CNT_W-1:0] count_w;
  logic             armed_w;
  logic             expire_w;

  rdt_event_arbiter u_arb (
    .restart_i (restart_i),
    .tick_i    (tick_i),
    .ev_o      (ev_w),
    .restart_o (restart_w),
    .advance_o (advance_w)
  );

  rdt_delay_clamp #(.CNT_W(CNT_W)) u_clamp (
    .delay_i     (delay_i),
    .delay_eff_o (delay_eff_w)
  );

  rdt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_w),
    .advance_i   (advance_w),
    .delay_eff_i (delay_eff_w),
    .count_o     (count_w),
    .armed_o     (armed_w),
    .expire_o    (expire_w)
  );

  assign expire_o = expire_w;
endmodule

// File: rtl/rdt_checker.sv
module rdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             restart_i,
  input logic             tick_i,
  input logic             expire_o,
  input logic             armed_w,
  input logic [CNT_W-1:0] count_w,
  input logic [CNT_W-1:0] delay_eff_w
);
  // R1
  idle_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_w |-> !expire_o);
  // R2
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (armed_w && count_w == '0));
  // R3
  advance_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_w && tick_i && !restart_i && !expire_o) |=> (count_w == $past(count_w) + CNT_W'(1)));
  // R4
  expire_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> tick_i);
  // R6
  single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (!armed_w && !expire_o));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_w && !restart_i) |=> $stable(count_w));
  // R8
  nonzero_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_eff_w != '0);
  // R9
  restart_mutes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !expire_o);
endmodule

bind retrig_delay_timer rdt_checker #(.CNT_W(CNT_W)) u_rdt_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .restart_i   (restart_i),
  .tick_i      (tick_i),
  .expire_o    (expire_o),
  .armed_w     (armed_w),
  .count_w     (count_w),
  .delay_eff_w (delay_eff_w)
);

// File: tb/tb_retrig_delay_timer.sv
`timescale 1ns/1ps
module tb_retrig_delay_timer;
  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             restart_i = 1'b0;
  logic             tick_i = 1'b0;
  logic [CNT_W-1:0] delay_i = CNT_W'(3);
  logic             expire_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model: ticks seen since the latest restart, and whether still waiting
  bit waiting = 0;
  int seen = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk_i = ~clk_i;

  retrig_delay_timer #(.CNT_W(CNT_W)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .tick_i    (tick_i),
    .delay_i   (delay_i),
    .expire_o  (expire_o)
  );

  function automatic int target();
    return (delay_i == '0) ? 1 : int'(delay_i);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: expire_o=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one cycle: drive, compare in-cycle, advance model for the coming edge
  task automatic step(input string tag, input logic rs, input logic tk);
    logic exp;
    @(negedge clk_i);
    restart_i = rs;
    tick_i    = tk;
    #1;
    exp = waiting && tk && !rs && (seen + 1 == target());
    check(tag, expire_o, exp);
    if (rs) begin
      waiting = 1;
      seen = 0;
    end else if (tk && waiting) begin
      seen++;
      if (seen == target()) waiting = 0;
    end
  endtask

  task automatic do_reset(input logic [CNT_W-1:0] d);
    @(negedge clk_i);
    rst_ni = 1'b0;
    restart_i = 0;
    tick_i = 0;
    delay_i = d;
    waiting = 0;
    seen = 0;
    #1;
    check("R1 reset", expire_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(190000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expire_o=%0b expected=finished", expire_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(CNT_W'(3));
    // R1: ticks before any restart never expire
    for (int i = 0; i < 10; i++) step("R1 pre-restart", 0, 1);

    // R3/R4: plain count to 3
    step("R4 restart", 1, 0);
    step("R3 tick1", 0, 1);
    step("R3 idle", 0, 0);
    step("R3 tick2", 0, 1);
    step("R4 tick3 expires", 0, 1);
    // R6: no second expiry
    for (int i = 0; i < 8; i++) step("R6 after expiry", 0, 1);

    // R2: coincident restart and tick is not counted
    step("R2 restart+tick", 1, 1);
    step("R2 tick1", 0, 1);
    step("R2 tick2", 0, 1);
    step("R2 tick3 expires", 0, 1);

    // R5: retrigger before expiry
    step("R5 restart", 1, 0);
    step("R5 tick1", 0, 1);
    step("R5 tick2", 0, 1);
    step("R5 retrigger", 1, 0);
    step("R5 tick1b", 0, 1);
    step("R5 tick2b", 0, 1);
    step("R5 tick3b expires", 0, 1);

    // R9: restart with tick on the would-be expiry tick
    step("R9 restart", 1, 0);
    step("R9 tick1", 0, 1);
    step("R9 tick2", 0, 1);
    step("R9 restart+tick", 1, 1);
    step("R9 tick1b", 0, 1);
    step("R9 tick2b", 0, 1);
    step("R9 tick3b expires", 0, 1);

    // R8: zero delay behaves as one
    do_reset('0);
    step("R8 restart", 1, 0);
    step("R8 first tick expires", 0, 1);
    step("R8 silent", 0, 1);

    // R7: long idle run beyond counter range
    do_reset(CNT_W'(2));
    step("R7 restart", 1, 0);
    step("R7 tick1", 0, 1);
    step("R7 tick2 expires", 0, 1);
    for (int i = 0; i < 70000; i++) step("R7 saturated idle", 0, 1);
    step("R7 rearm", 1, 0);
    step("R7 rearm tick1", 0, 1);
    step("R7 rearm tick2 expires", 0, 1);

    // R4 sweep: delays 0..6 with pseudo-random strobes
    for (int d = 0; d <= 6; d++) begin
      do_reset(CNT_W'(d));
      for (int i = 0; i < 500; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step("R4 sweep", (lfsr[3:0] == 4'h0), lfsr[5] | lfsr[6]);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule